// File: doc/BRIEF.md
# Programmable AND-Plane Logic Array with Output Feedback

This block is a small sum-of-products logic array whose AND plane is set up by writing configuration rows, while its OR plane is wired at design time. Every output owns a fixed group of product terms and ORs only that group. A product term can never be shared with another output.

Each product term may use the true or inverted form of every primary input. It may also use the true or inverted form of every output, which is fed back into the AND plane. A function that needs more products than one group holds is therefore split. Part of it is built on one output, and a second output ORs that output back in through feedback. Configurations must not close a loop through feedback. With an acyclic configuration, the outputs are a combinational function of the primary inputs within the same cycle.

Configuration is written one product row per clock through a simple write port. Reset loads every row with a pattern that forces its product to 0.

Top module: `pal_feedback_array`

## Requirements
- R1: While reset is held and after it is released, before any write, every product row holds the forced-zero pattern (literal 0 connected in both forms, row value 0x0003), so every output reads 0 for every input value.
- R2: A write with `cfg_we` high is taken at the rising clock edge. The new row affects the outputs from that edge onward, and not before it.
- R3: A write whose `cfg_idx` is 12 or above (no such product term exists) changes no product term and no output.
- R4: Row encoding: bit 2j connects the true form and bit 2j+1 connects the inverted form of literal j. Literals 0 to 3 are `in_pins[0..3]` and literals 4 to 7 are `out_pins[0..3]`. A product is the AND of its connected literals, and a row with nothing connected evaluates to 1.
- R5: A row that connects both forms of the same literal evaluates to 0 for every input value.
- R6: Output k is the OR of product terms 3k, 3k+1 and 3k+2 only. A row written into one group never changes another output, except through a feedback literal.
- R7: With an acyclic configuration, feedback literals carry the settled value of the output they name. Chains that run through up to all four outputs resolve within the same cycle.
- R8: While `cfg_we` is low, the values on `cfg_idx` and `cfg_row` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; configuration writes use its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads forced-zero rows |
| in_pins | input | 4 | Primary inputs, literals 0 to 3 |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 4 | Product-term index to write (0 to 11 valid) |
| cfg_row | input | 16 | AND-row word, two connect bits per literal |
| out_pins | output | 4 | Outputs, each the OR of its own three product terms |

## Verification
The bench builds the block with its default sizes: four inputs, four outputs and three products per output. These sizes keep every input combination within an exhaustive 16-value sweep after each configuration change. A feedback chain that passes through all four outputs is reachable, so the deepest settling path is exercised. Twelve product terms in a 4-bit index leave indices 12 to 15 free to probe ignored writes. A five-product function is split across two outputs and compared over all 16 inputs against a minterm list written independently of any row encoding.

// File: rtl/pal_fb_pkg.sv
package pal_fb_pkg;

    parameter int unsigned N_IN  = 4;
    parameter int unsigned N_OUT = 4;
    parameter int unsigned N_GRP = 3;

    localparam int unsigned N_LIT  = N_IN + N_OUT;
    localparam int unsigned ROW_W  = 2 * N_LIT;
    localparam int unsigned N_TERM = N_OUT * N_GRP;
    localparam int unsigned IDX_W  = $clog2(N_TERM);

    typedef logic [ROW_W-1:0] row_t;
    typedef logic [N_LIT-1:0] lit_vec_t;

    // Literal 0 connected in both forms: the product can never be 1.
    localparam row_t ROW_DEAD = row_t'(3);

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        row_t             row;
    } cfg_wr_t;

    // A product is 1 unless a connected literal form is false.
    function automatic logic term_value(input row_t r, input lit_vec_t l);
        logic v;
        v = 1'b1;
        for (int j = 0; j < int'(N_LIT); j++) begin
            if (r[2*j] && !l[j])
                v = 1'b0;
            if (r[2*j+1] && l[j])
                v = 1'b0;
        end
        return v;
    endfunction

    function automatic logic idx_valid(input logic [IDX_W-1:0] idx);
        return {1'b0, idx} < (IDX_W+1)'(N_TERM);
    endfunction

endpackage

// File: rtl/pal_cfg_store.sv
module pal_cfg_store
    import pal_fb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cfg_wr_t wr,
    output row_t    rows [N_TERM]
);

    for (genvar t = 0; t < int'(N_TERM); t++) begin : g_row
        logic hit;
        assign hit = wr.we && (wr.idx == IDX_W'(t));

        always_ff @(posedge clk) begin
            if (rst)
                rows[t] <= ROW_DEAD;
            else if (hit)
                rows[t] <= wr.row;
        end
    end

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane
    import pal_fb_pkg::*;
(
    input  lit_vec_t          lits,
    input  row_t              rows [N_TERM],
    output logic [N_TERM-1:0] terms
);

    for (genvar t = 0; t < int'(N_TERM); t++) begin : g_term
        assign terms[t] = term_value(rows[t], lits);
    end

endmodule

// File: rtl/pal_or_fixed.sv
module pal_or_fixed
    import pal_fb_pkg::*;
(
    input  logic [N_TERM-1:0] terms,
    output logic [N_OUT-1:0]  sums
);

    for (genvar k = 0; k < int'(N_OUT); k++) begin : g_sum
        assign sums[k] = |terms[k*N_GRP +: N_GRP];
    end

endmodule

// File: rtl/pal_feedback_array.sv
module pal_feedback_array
    import pal_fb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  in_pins,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [ROW_W-1:0] cfg_row,
    output logic [N_OUT-1:0] out_pins
);

    cfg_wr_t wr;
    row_t    term_rows [N_TERM];

    always_comb begin
        wr.we  = cfg_we;
        wr.idx = cfg_idx;
        wr.row = cfg_row;
    end

    pal_cfg_store u_store (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .rows (term_rows)
    );

    // Feedback is unrolled into N_OUT passes so the netlist has no
    // combinational loop; an acyclic chain of depth d settles by pass d+1.
    logic [N_OUT-1:0] stage [N_OUT+1];
    assign stage[0] = '0;

    for (genvar p = 0; p < int'(N_OUT); p++) begin : g_pass
        lit_vec_t         lits;
        logic [N_TERM-1:0] terms;

        assign lits = {stage[p], in_pins};

        pal_and_plane u_and (
            .lits  (lits),
            .rows  (term_rows),
            .terms (terms)
        );

        pal_or_fixed u_or (
            .terms (terms),
            .sums  (stage[p+1])
        );
    end

    assign out_pins = stage[N_OUT];

endmodule

// File: rtl/pal_fb_chk.sv
module pal_fb_chk
    import pal_fb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [IDX_W-1:0] cfg_idx,
    input logic [ROW_W-1:0] cfg_row,
    input row_t             rows [N_TERM],
    input logic [N_OUT-1:0] out_pins
);

    logic [N_TERM*ROW_W-1:0] flat;

    always_comb begin
        for (int t = 0; t < int'(N_TERM); t++)
            flat[t*ROW_W +: ROW_W] = rows[t];
    end

    // R1: the cycle after reset every output is dark
    a_r1_reset_dark: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_pins == '0));

    // R2: a valid write lands in the addressed row at the edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && idx_valid(cfg_idx)) |=> (rows[$past(cfg_idx)] == $past(cfg_row)));

    // R3: an index beyond the last term leaves every row untouched
    a_r3_high_index_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !idx_valid(cfg_idx)) |=> $stable(flat));

    // R8: with the write enable low the configuration holds
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(flat));

endmodule

bind pal_feedback_array pal_fb_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_row  (cfg_row),
    .rows     (term_rows),
    .out_pins (out_pins)
);

// File: tb/sim_pal_feedback_array.sv
module sim_pal_feedback_array;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  in_pins;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [15:0] cfg_row;
    logic [3:0]  out_pins;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_rows [12];

    always #5 clk = ~clk;

    pal_feedback_array u0 (
        .clk      (clk),
        .rst      (rst),
        .in_pins  (in_pins),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_row  (cfg_row),
        .out_pins (out_pins)
    );

    // Row bit for literal j (0..3 inputs, 4..7 outputs), neg selects inverted form (R4)
    function automatic logic [15:0] lit(input int j, input bit neg);
        return 16'(1) << (2*j + int'(neg));
    endfunction

    // Reference: iterate all outputs to a fixed point from zero
    function automatic logic [3:0] model(input logic [3:0] inp);
        logic [3:0] fb = 4'b0;
        logic [3:0] nx;
        for (int it = 0; it < 8; it++) begin
            nx = 4'b0;
            for (int k = 0; k < 4; k++) begin
                for (int g = 0; g < 3; g++) begin
                    logic p = 1'b1;
                    for (int j = 0; j < 8; j++) begin
                        logic v = (j < 4) ? inp[j] : fb[j-4];
                        if (m_rows[k*3+g][2*j] && !v) p = 1'b0;
                        if (m_rows[k*3+g][2*j+1] && v) p = 1'b0;
                    end
                    if (p) nx[k] = 1'b1;
                end
            end
            fb = nx;
        end
        return fb;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: out_pins=%b expected %b (in_pins=%b)", tag, act, exp, in_pins);
        end
    endtask

    // Drive one cycle, compare before the edge, update the model at the edge
    task automatic apply(input logic we, input logic [3:0] idx, input logic [15:0] row,
                         input logic [3:0] inp, input string tag);
        cfg_we  = we;
        cfg_idx = idx;
        cfg_row = row;
        in_pins = inp;
        #3;
        chk(tag, out_pins, model(inp));
        @(posedge clk);
        if (we && idx < 4'd12) m_rows[idx] = row;
        #1;
    endtask

    task automatic sweep(input string tag);
        for (int v = 0; v < 16; v++) apply(1'b0, 4'd0, 16'h0000, 4'(v), tag);
    endtask

    task automatic prog(input int idx, input logic [15:0] row, input string tag);
        apply(1'b1, 4'(idx), row, 4'd0, tag);
    endtask

    task automatic spot(input logic [3:0] inp, input int bitpos, input logic exp, input string tag);
        cfg_we  = 1'b0;
        in_pins = inp;
        #1;
        checks++;
        if (out_pins[bitpos] !== exp) begin
            fails++;
            $display("FAIL %s: out_pins[%0d]=%b expected %b (in_pins=%b)",
                     tag, bitpos, out_pins[bitpos], exp, inp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] five_set;
        rst     = 1'b1;
        cfg_we  = 1'b0;
        cfg_idx = 4'd0;
        cfg_row = 16'h0;
        in_pins = 4'd0;
        for (int t = 0; t < 12; t++) m_rows[t] = 16'h0003;
        @(posedge clk);
        @(posedge clk);
        #1;
        spot(4'hF, 0, 1'b0, "R1 in reset");
        rst = 1'b0;

        // R1: forced-zero rows after reset
        sweep("R1 reset rows");

        // R4 / R2: W = A B C' + A' B' C D' on output 0 (A..D = in0..in3)
        prog(0, lit(0,0) | lit(1,0) | lit(2,1), "R2 write t0");
        prog(1, lit(0,1) | lit(1,1) | lit(2,0) | lit(3,1), "R2 write t1");
        sweep("R4 two-product W");
        spot(4'b0011, 0, 1'b1, "R4 W at ABC'");
        spot(4'b0100, 0, 1'b1, "R4 W at A'B'CD'");
        spot(4'b0111, 0, 1'b0, "R4 W at ABC");
        spot(4'b1100, 0, 1'b0, "R4 W at A'B'CD");

        // R4: empty row is 1; R2: not visible before the edge
        in_pins = 4'd0;
        apply(1'b1, 4'd3, 16'h0000, 4'd0, "R2 before edge");
        spot(4'd0, 1, 1'b1, "R4 empty row");
        sweep("R4 empty row sweep");

        // R5: both forms of one literal
        prog(3, lit(2,0) | lit(2,1), "R5 write");
        sweep("R5 contradictory row");
        prog(3, lit(6,0) | lit(6,1), "R5 write fb");
        sweep("R5 contradictory feedback row");

        // R6: a term in output 2's group leaves others alone
        prog(6, lit(1,0), "R6 write t6");
        sweep("R6 group isolation");
        spot(4'b0010, 2, 1'b1, "R6 out2 follows B");
        spot(4'b0010, 0, 1'b0, "R6 out0 unaffected");
        spot(4'b0010, 1, 1'b0, "R6 out1 unaffected");

        // R7: five products split over out0 and out1 through feedback
        prog(2, lit(0,1) | lit(1,1) | lit(2,1) | lit(3,0), "R7 write t2");
        prog(3, lit(4,0), "R7 write t3");
        prog(4, lit(0,0) | lit(1,0) | lit(2,0) | lit(3,0), "R7 write t4");
        prog(5, lit(0,1) | lit(1,0) | lit(2,1) | lit(3,1), "R7 write t5");
        five_set = 16'b1000_1001_0001_1100; // minterms 2,3,4,8,11,15
        for (int v = 0; v < 16; v++) spot(4'(v), 1, five_set[v], "R7 five-product exhaustive");
        sweep("R7 five-product sweep");

        // R7: chain out0 -> out1 -> out2 -> out3 (inverted)
        prog(6, lit(5,0), "R7 write t6");
        prog(9, lit(6,1), "R7 write t9");
        sweep("R7 deep chain");
        for (int v = 0; v < 16; v++) spot(4'(v), 3, ~five_set[v], "R7 chain end");

        // R3: writes to absent terms are ignored
        apply(1'b1, 4'd12, 16'h0000, 4'd0, "R3 idx12");
        apply(1'b1, 4'd13, 16'h0000, 4'd0, "R3 idx13");
        apply(1'b1, 4'd15, 16'h0000, 4'd0, "R3 idx15");
        sweep("R3 after ignored writes");

        // R8: write enable low with live index/row
        for (int v = 0; v < 12; v++) apply(1'b0, 4'(v), 16'h0000, 4'(v), "R8 enable low");
        sweep("R8 after idle");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule